// File: doc/BRIEF.md
# Capture/Compare/PWM Timer Channel

This block is one channel attached to a shared free-running timer. It does not own the counter. It watches the counter value, a strobe that marks each counter update, the overflow event and the counting direction. From these it does one of four jobs: it latches the counter when the input pin shows a chosen edge, it acts on the pin when the counter meets a programmed value, or it shapes an edge-aligned or a center-aligned PWM waveform.

Software sets up the channel through a 6-bit control register and a CNT_W-bit value register. In capture mode the value register holds the captured count. In the other modes it holds the compare value. An event flag in the control register is set by every capture or compare event. Software clears the flag with a read-then-write sequence. An edge/level setting of zero gives the pin back to general-purpose logic.

Top module: `tmr_chan`

## Requirements
- R1: After reset the control register reads 0, the value register reads 0, and flag_o, pin_o and pin_oe_o are all 0.
- R2: The control register layout is bit 5 = event flag (read-only from the write port), bit 4 = center-aligned select, bits 3:2 = mode bits, bits 1:0 = edge/level. With bit 4 set the channel is center-aligned PWM, whatever the mode bits hold. With bit 4 clear, mode bits 00 select capture, 01 select compare and 1X select edge-aligned PWM. Bits 4:0 read back as written.
- R3: In capture mode, edge/level 01 captures on rising pin edges only, 10 on falling edges only and 11 on both. The pin passes through two synchronizer flops and one edge-detect flop. A pin change that is set up before clock edge k is captured at edge k+2.
- R4: A capture loads the counter value present at the capturing edge into the value register and sets the flag. A value-register write in the same cycle loses to the capture.
- R5: In compare mode a compare event (counter update with cnt_i equal to the value register) acts on the pin as follows: edge/level 00 leaves the pin undriven, 01 toggles it, 10 drives it low and 11 drives it high. The new level shows after that clock edge.
- R6: In edge-aligned PWM, an overflow drives the active level and a compare event drives the inactive level. The match wins when both occur together. Edge/level 10 makes the active level high; X1 makes it low. With a value of 0 the output never shows the active level. With a value above the modulo the output always shows it.
- R7: In center-aligned PWM with edge/level 10, a compare event while counting up drives the pin low and one while counting down drives it high. Edge/level X1 gives the opposite levels.
- R8: Edge/level 00 holds pin_oe_o and pin_o at 0 in every mode, and in capture mode it disables capture.
- R9: The flag is cleared only by a control write with bit 5 = 0 that follows a control read taken while the flag was set. Any control write ends that permission. A write without a prior read leaves the flag set, and writing bit 5 = 1 never sets it.
- R10: A capture or compare event in the same cycle as a permitted clearing write leaves the flag set.
- R11: The value register reads back what was written on the cycle after the write.
- R12: Compare events need cnt_tick_i high. Every compare event sets the flag, including the software-only compare with edge/level 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Shared counter value |
| cnt_tick_i | input | 1 | Counter took a new value this cycle |
| cnt_down_i | input | 1 | Current counter value was reached counting down |
| cnt_ovf_i | input | 1 | Counter wrapped to zero this cycle |
| pin_i | input | 1 | Channel pin input level |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 6 | Control register write data |
| ctrl_re_i | input | 1 | Control register read strobe |
| ctrl_rdata_o | output | 6 | Control register read data |
| val_we_i | input | 1 | Value register write strobe |
| val_wdata_i | input | CNT_W | Value register write data |
| val_rdata_o | output | CNT_W | Value register read data |
| pin_o | output | 1 | Pin drive level (0 when not driving) |
| pin_oe_o | output | 1 | Timer drives the pin |
| flag_o | output | 1 | Channel event flag |

## Verification
Register writes, compare events and PWM transitions all show one clock edge after the cycle that causes them. The pin path is slower: a pin edge is captured three clock edges after it is applied, through two synchronizer stages and the edge-detect stage. The bench drives all inputs at the falling clock edge. A behavioural model in the bench advances at each rising edge from the same inputs and keeps an explicit four-deep pin history for the capture delay. Every output is compared with that model at the next falling edge. Directed checks sample at the same point: capture checks wait two steps to confirm no early flag, then one more step. Duty checks count high samples over exactly one counter period.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  localparam int CTRL_W  = 6;
  localparam int FLAG_B  = 5;
  localparam int CTR_B   = 4;

  typedef enum logic [1:0] {
    MODE_CAP  = 2'd0,
    MODE_CMP  = 2'd1,
    MODE_EPWM = 2'd2,
    MODE_CPWM = 2'd3
  } ch_mode_e;

  typedef struct packed {
    logic       center;
    logic [1:0] ms;
    logic [1:0] els;
  } ch_cfg_t;
endpackage

// File: rtl/tmr_chan_sync.sv
module tmr_chan_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;
  logic              lvl;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign lvl = chain_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= lvl;
  end

  assign rise_o = lvl & ~last_q;
  assign fall_o = ~lvl & last_q;
endmodule

// File: rtl/tmr_chan_decode.sv
module tmr_chan_decode
  import tmr_chan_pkg::*;
(
  input  ch_cfg_t  cfg_i,
  output ch_mode_e mode_o,
  output logic     cap_rise_o,
  output logic     cap_fall_o,
  output logic     drive_o,
  output logic     active_o
);
  always_comb begin
    if (cfg_i.center)     mode_o = MODE_CPWM;
    else if (cfg_i.ms[1]) mode_o = MODE_EPWM;
    else if (cfg_i.ms[0]) mode_o = MODE_CMP;
    else                  mode_o = MODE_CAP;
  end

  assign cap_rise_o = (mode_o == MODE_CAP) & cfg_i.els[0];
  assign cap_fall_o = (mode_o == MODE_CAP) & cfg_i.els[1];
  assign drive_o    = (mode_o != MODE_CAP) & (|cfg_i.els);
  // PWM asserted level: high for 10, low for X1
  assign active_o   = ~cfg_i.els[0];
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              ctrl_re_i,
  input  logic              val_we_i,
  input  logic [CNT_W-1:0]  val_wdata_i,
  input  logic              cap_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              evt_i,
  output ch_cfg_t           cfg_o,
  output logic              flag_o,
  output logic [CNT_W-1:0]  val_o
);
  ch_cfg_t          cfg_q;
  logic [CNT_W-1:0] val_q;
  logic             flag_q;
  logic             arm_q;
  logic             clr;

  assign clr = ctrl_we_i & arm_q & ~ctrl_wdata_i[FLAG_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (ctrl_we_i) begin
      cfg_q <= ch_cfg_t'(ctrl_wdata_i[CTR_B:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       val_q <= '0;
    else if (cap_i)    val_q <= cnt_i;
    else if (val_we_i) val_q <= val_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 arm_q <= 1'b0;
    else if (ctrl_we_i)          arm_q <= 1'b0;
    else if (ctrl_re_i & flag_q) arm_q <= 1'b1;
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (evt_i) flag_q <= 1'b1;
    else if (clr)   flag_q <= 1'b0;
  end

  assign cfg_o  = cfg_q;
  assign flag_o = flag_q;
  assign val_o  = val_q;
endmodule

// File: rtl/tmr_chan_out.sv
module tmr_chan_out
  import tmr_chan_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ch_mode_e mode_i,
  input  logic [1:0] els_i,
  input  logic     active_i,
  input  logic     match_i,
  input  logic     ovf_i,
  input  logic     down_i,
  output logic     out_o
);
  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
    end else begin
      unique case (mode_i)
        MODE_CMP: begin
          if (match_i) begin
            unique case (els_i)
              2'b01:   out_q <= ~out_q;
              2'b10:   out_q <= 1'b0;
              2'b11:   out_q <= 1'b1;
              default: out_q <= out_q;
            endcase
          end
        end
        MODE_EPWM: begin
          if (match_i)    out_q <= ~active_i;
          else if (ovf_i) out_q <= active_i;
        end
        MODE_CPWM: begin
          if (match_i) out_q <= down_i ? active_i : ~active_i;
        end
        default: out_q <= out_q;
      endcase
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              cnt_tick_i,
  input  logic              cnt_down_i,
  input  logic              cnt_ovf_i,
  input  logic              pin_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              ctrl_re_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  input  logic              val_we_i,
  input  logic [CNT_W-1:0]  val_wdata_i,
  output logic [CNT_W-1:0]  val_rdata_o,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              flag_o
);
  ch_cfg_t          cfg;
  ch_mode_e         mode;
  logic [CNT_W-1:0] val;
  logic             flag;
  logic             rise, fall;
  logic             cap_rise_en, cap_fall_en;
  logic             drive, active;
  logic             cap, match, out;

  tmr_chan_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  tmr_chan_decode u_decode (
    .cfg_i      (cfg),
    .mode_o     (mode),
    .cap_rise_o (cap_rise_en),
    .cap_fall_o (cap_fall_en),
    .drive_o    (drive),
    .active_o   (active)
  );

  assign cap   = (rise & cap_rise_en) | (fall & cap_fall_en);
  assign match = cnt_tick_i & (cnt_i == val) & (mode != MODE_CAP);

  tmr_chan_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .ctrl_re_i    (ctrl_re_i),
    .val_we_i     (val_we_i),
    .val_wdata_i  (val_wdata_i),
    .cap_i        (cap),
    .cnt_i        (cnt_i),
    .evt_i        (cap | match),
    .cfg_o        (cfg),
    .flag_o       (flag),
    .val_o        (val)
  );

  tmr_chan_out u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .els_i    (cfg.els),
    .active_i (active),
    .match_i  (match),
    .ovf_i    (cnt_ovf_i),
    .down_i   (cnt_down_i),
    .out_o    (out)
  );

  assign ctrl_rdata_o = {flag, cfg};
  assign val_rdata_o  = val;
  assign flag_o       = flag;
  assign pin_oe_o     = drive;
  assign pin_o        = drive & out;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic             cnt_tick_i,
  input logic             cnt_down_i,
  input logic             ctrl_we_i,
  input logic             clr_bit_i,
  input logic [5:0]       ctrl_rdata_o,
  input logic [CNT_W-1:0] val_rdata_o,
  input logic             pin_o,
  input logic             pin_oe_o,
  input logic             flag_o
);
  a_r8_released_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[1:0] == 2'b00 |-> !pin_oe_o && !pin_o);

  a_r4_capture_loads_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flag_o) && $past(ctrl_rdata_o[4:2] == 3'b000)) |-> val_rdata_o == $past(cnt_i));

  a_r9_clear_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(ctrl_we_i && !clr_bit_i));

  a_r5_toggle_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_rdata_o[4:0] == 5'b00101 && cnt_tick_i && cnt_i == val_rdata_o && !ctrl_we_i)
    |-> pin_o != $past(pin_o));

  a_r6_edge_pwm_match_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ctrl_rdata_o[4] && ctrl_rdata_o[3] && ctrl_rdata_o[1:0] == 2'b10 &&
          cnt_tick_i && cnt_i == val_rdata_o && !ctrl_we_i) |-> !pin_o);

  a_r7_center_up_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_rdata_o[4] && ctrl_rdata_o[1:0] == 2'b10 && cnt_tick_i && !cnt_down_i &&
          cnt_i == val_rdata_o && !ctrl_we_i) |-> !pin_o);

  a_r12_no_event_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!cnt_tick_i && ctrl_rdata_o[4:2] != 3'b000 && !flag_o) |-> !flag_o);
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cnt_i        (cnt_i),
  .cnt_tick_i   (cnt_tick_i),
  .cnt_down_i   (cnt_down_i),
  .ctrl_we_i    (ctrl_we_i),
  .clr_bit_i    (ctrl_wdata_i[5]),
  .ctrl_rdata_o (ctrl_rdata_o),
  .val_rdata_o  (val_rdata_o),
  .pin_o        (pin_o),
  .pin_oe_o     (pin_oe_o),
  .flag_o       (flag_o)
);

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb;
  localparam int W    = 16;
  localparam int MODV = 15;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_ni = 1'b0;
  logic [W-1:0] cnt = '0;
  logic         tick = 0, down = 0, ovf = 0, pin = 0;
  logic         cwe = 0, cre = 0, vwe = 0;
  logic [5:0]   cwd = '0;
  logic [W-1:0] vwd = '0;
  logic [5:0]   crd;
  logic [W-1:0] vrd;
  logic         pin_o, oe, flag;

  tmr_chan #(.CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_i(cnt), .cnt_tick_i(tick), .cnt_down_i(down),
    .cnt_ovf_i(ovf), .pin_i(pin), .ctrl_we_i(cwe), .ctrl_wdata_i(cwd), .ctrl_re_i(cre),
    .ctrl_rdata_o(crd), .val_we_i(vwe), .val_wdata_i(vwd), .val_rdata_o(vrd),
    .pin_o(pin_o), .pin_oe_o(oe), .flag_o(flag)
  );

  int    checks = 0, fails = 0;
  string req = "R1";
  bit    run = 0, center = 0, dir_dn = 0, done = 0;

  // behavioural reference model
  int q[$];
  int m_flag, m_arm, m_val, m_out, m_ctr, m_ms, m_els;

  function automatic int m_mode();
    if (m_ctr != 0) return 3;
    if (m_ms >= 2)  return 2;
    if (m_ms == 1)  return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    int s, p, md, act;
    bit hit, match, clr;
    if (!rst_ni) begin
      m_flag = 0; m_arm = 0; m_val = 0; m_out = 0; m_ctr = 0; m_ms = 0; m_els = 0;
      q = '{0, 0, 0, 0};
    end else begin
      q.push_front(int'(pin));
      s = q[2]; p = q[3];
      void'(q.pop_back());
      md    = m_mode();
      hit   = (md == 0) && (((m_els & 1) != 0 && s == 1 && p == 0) ||
                            ((m_els & 2) != 0 && s == 0 && p == 1));
      match = (md != 0) && tick && (int'(cnt) == m_val);
      act   = (m_els % 2 == 0) ? 1 : 0;
      if (md == 1 && match) begin
        if (m_els == 1) m_out = 1 - m_out;
        else if (m_els == 2) m_out = 0;
        else if (m_els == 3) m_out = 1;
      end else if (md == 2) begin
        if (match) m_out = 1 - act;
        else if (ovf) m_out = act;
      end else if (md == 3 && match) begin
        m_out = down ? act : 1 - act;
      end
      clr = cwe && m_arm == 1 && !cwd[5];
      if (hit || match) m_flag = 1;
      else if (clr)     m_flag = 0;
      if (cwe) m_arm = 0;
      else if (cre && m_flag == 1 && !(hit || match && 0)) m_arm = 1;
      if (hit) m_val = int'(cnt);
      else if (vwe) m_val = int'(vwd);
      if (cwe) begin
        m_ctr = int'(cwd[4]); m_ms = int'(cwd[3:2]); m_els = int'(cwd[1:0]);
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int eoe;
    eoe = (m_els != 0 && m_mode() != 0) ? 1 : 0;
    chk("pin_oe_o", 32'(oe), 32'(eoe));
    chk("pin_o", 32'(pin_o), 32'(eoe != 0 ? m_out : 0));
    chk("flag_o", 32'(flag), 32'(m_flag));
    chk("val_rdata_o", 32'(vrd), 32'(m_val));
    chk("ctrl_rdata_o", 32'(crd), 32'((m_flag << 5) | (m_ctr << 4) | (m_ms << 2) | m_els));
  endtask

  task automatic drive_cnt();
    if (!run) return;
    tick = 1;
    if (!center) begin
      ovf  = (int'(cnt) == MODV);
      cnt  = ovf ? '0 : cnt + 1'b1;
      down = 0;
    end else begin
      ovf = 0;
      if (!dir_dn) begin
        if (int'(cnt) >= MODV) begin dir_dn = 1; cnt = cnt - 1'b1; end
        else cnt = cnt + 1'b1;
      end else begin
        if (cnt == 0) begin dir_dn = 0; cnt = cnt + 1'b1; end
        else cnt = cnt - 1'b1;
      end
      down = dir_dn;
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      compare_all();
      drive_cnt();
    end
  endtask

  task automatic wr_ctrl(logic [5:0] v);
    cwe = 1; cwd = v; step(1); cwe = 0;
  endtask
  task automatic wr_val(logic [W-1:0] v);
    vwe = 1; vwd = v; step(1); vwe = 0;
  endtask
  task automatic rd_ctrl();
    cre = 1; step(1); cre = 0;
  endtask
  task automatic duty(int exp_hi, string what);
    int hi = 0;
    repeat (exp_hi >= 0 ? 1 : 1) begin end
    for (int i = 0; i < (center ? 30 : 16); i++) begin
      step(1);
      hi += int'(pin_o);
    end
    chk(what, 32'(hi), 32'(exp_hi));
  endtask

  initial begin
    logic [W-1:0] e;
    step(3);
    rst_ni = 1;
    step(1);
    req = "R1";
    chk("ctrl reset", 32'(crd), 0);
    chk("val reset", 32'(vrd), 0);
    chk("flag reset", 32'(flag), 0);
    chk("pin reset", 32'({pin_o, oe}), 0);

    req = "R11";
    wr_val(16'h1234);
    chk("val readback", 32'(vrd), 32'h1234);
    run = 1;

    req = "R3";
    wr_ctrl(6'h01);
    step(4);
    pin = 1; step(2);
    chk("no early capture", 32'(flag), 0);
    e = cnt; step(1);
    chk("rise capture flag", 32'(flag), 1);
    req = "R4";
    chk("captured count", 32'(vrd), 32'(e));

    req = "R9";
    wr_ctrl(6'h21);
    chk("write 1 no clear", 32'(flag), 1);
    wr_ctrl(6'h01);
    chk("write 0 without read", 32'(flag), 1);
    rd_ctrl(); wr_ctrl(6'h02);
    chk("read then write 0 clears", 32'(flag), 0);

    req = "R3";
    step(3);
    chk("fall mode: no capture", 32'(flag), 0);
    pin = 0; step(2);
    e = cnt; step(1);
    chk("fall capture", 32'(flag), 1);
    chk("fall captured value", 32'(vrd), 32'(e));
    rd_ctrl(); wr_ctrl(6'h01);
    pin = 1; step(4);
    pin = 0; step(6);
    chk("rise mode ignores fall", 32'(flag), 1);
    rd_ctrl(); wr_ctrl(6'h03);
    pin = 1; step(3);
    chk("both: rise", 32'(flag), 1);
    rd_ctrl(); wr_ctrl(6'h03);
    pin = 0; step(2);
    e = cnt; step(1);
    chk("both: fall", 32'(flag), 1);
    chk("both: value", 32'(vrd), 32'(e));

    req = "R4";
    rd_ctrl(); wr_ctrl(6'h01);
    pin = 1; step(2);
    e = cnt; vwe = 1; vwd = 16'hBEEF; step(1); vwe = 0;
    chk("capture beats write", 32'(vrd), 32'(e));

    req = "R8";
    rd_ctrl(); wr_ctrl(6'h00);
    pin = 0; step(4); pin = 1; step(4);
    chk("els00 no capture", 32'(flag), 0);
    chk("els00 oe", 32'(oe), 0);

    req = "R5";
    wr_val(16'd5);
    wr_ctrl(6'h05); step(40);
    wr_ctrl(6'h06); step(20);
    chk("clear on match", 32'(pin_o), 0);
    wr_ctrl(6'h07); step(20);
    chk("set on match", 32'(pin_o), 1);
    wr_ctrl(6'h04); step(20);
    chk("software compare oe", 32'(oe), 0);

    req = "R12";
    run = 0; tick = 0; ovf = 0; down = 0; cnt = 16'd5;
    rd_ctrl(); wr_ctrl(6'h04);
    step(3);
    chk("no tick no event", 32'(flag), 0);
    tick = 1; step(1); tick = 0;
    chk("tick match sets flag", 32'(flag), 1);

    req = "R10";
    rd_ctrl();
    cwe = 1; cwd = 6'h04; tick = 1; step(1); cwe = 0; tick = 0;
    chk("set beats clear", 32'(flag), 1);
    rd_ctrl(); wr_ctrl(6'h04);
    chk("clear after", 32'(flag), 0);

    req = "R6";
    run = 1;
    wr_val(16'd6); wr_ctrl(6'h0A); step(20);
    duty(6, "high-true duty");
    wr_ctrl(6'h09); step(20);
    duty(10, "low-true duty");
    wr_ctrl(6'h0A); wr_val(16'd0); step(20);
    duty(0, "zero duty");
    wr_val(16'd20); step(20);
    duty(16, "full duty");
    req = "R8";
    wr_ctrl(6'h08); step(20);
    chk("epwm els00 oe", 32'({oe, pin_o}), 0);

    req = "R7";
    center = 1; dir_dn = 0;
    wr_val(16'd6); wr_ctrl(6'h12); step(40);
    duty(12, "center high-true");
    req = "R2";
    wr_ctrl(6'h1E); step(40);
    chk("ctrl readback", 32'(crd[4:0]), 32'h1E);
    duty(12, "center ignores mode bits");
    req = "R7";
    wr_ctrl(6'h11); step(40);
    duty(18, "center low-true");
    req = "R8";
    wr_ctrl(6'h10); step(30);
    chk("cpwm els00 oe", 32'({oe, pin_o}), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule